// File: doc/BRIEF.md
# Instruction Address Sequencer

This block owns the instruction address of a small processor core. It takes decoded control strobes, a branch offset, a target address and an interrupt request with its number. Every clock it picks the next instruction address from these sources: the address that follows in sequence, an absolute jump, a branch relative to the current address, a subroutine entry, a return, or an interrupt handler. The address register is only as wide as the instruction memory needs, 12 bits by default. All address arithmetic works modulo that width, so relative branches can cross from the bottom of memory to the top, and from the top back to the bottom.

Return addresses are held in a small hardware stack. A call pushes the address after the call, and an interrupt pushes the interrupted address itself. One return strobe pops either kind. Handler addresses come from a small table of registers, loaded through a write port. Two sticky flags record a push onto a full stack and a pop from an empty stack. Only a reset clears them.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high on a clock edge, `pc` becomes 0, both stack flags become 0 and the stack is emptied. `irq_taken` is 0 while `rst` is high.
- R2: With `fetch_vld` high and no transfer strobe active, `pc` advances by exactly 1. With `fetch_vld` low, `pc` and the stack hold, and every strobe is ignored.
- R3: `jump_en` loads `target` into `pc` and leaves the stack untouched.
- R4: `branch_en` with `branch_cond` high loads `pc` plus the sign-extended 8-bit two's-complement `branch_ofs`. With `branch_cond` low, `pc` advances by 1 instead.
- R5: Increment and relative-branch results keep only the low 12 bits. 0xFFF + 1 gives 0x000, and 0x000 + (-1) gives 0xFFF.
- R6: `call_en` pushes `pc`+1 and loads `target`. `ret_en` pops the top entry into `pc`.
- R7: The stack is last-in first-out and holds 8 entries. Eight nested calls return in reverse order.
- R8: A push onto a full stack is dropped and sets `stk_overflow`, but the PC still transfers. A pop from an empty stack leaves `pc` unchanged and sets `stk_underflow`. Both flags stay set until reset.
- R9: When `irq_req` and `fetch_vld` are both high, `irq_taken` is high in that cycle. The current `pc` is pushed and `pc` loads the handler entry selected by `irq_num`. A later return resumes at the interrupted address. With `fetch_vld` low, no interrupt is taken.
- R10: When strobes coincide, the order of precedence is interrupt, return, call, jump, taken branch, increment.
- R11: While `stall` is high, `pc` and the stack hold, and no interrupt is taken.
- R12: A write with `vec_we` high stores `vec_addr` into handler entry `vec_idx` (2 bits, 4 entries, all 0 after reset). Writes are accepted whether or not the core is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze address and stack |
| fetch_vld | input | 1 | An instruction boundary: strobes are valid |
| jump_en | input | 1 | Absolute jump |
| branch_en | input | 1 | Relative branch |
| branch_cond | input | 1 | Branch condition |
| call_en | input | 1 | Subroutine call |
| ret_en | input | 1 | Return (from subroutine or interrupt) |
| branch_ofs | input | 8 | Signed branch offset |
| target | input | 12 | Jump or call destination |
| irq_req | input | 1 | Interrupt request |
| irq_num | input | 2 | Interrupt number |
| vec_we | input | 1 | Handler table write enable |
| vec_idx | input | 2 | Handler table entry to write |
| vec_addr | input | 12 | Handler address to write |
| pc | output | 12 | Current instruction address |
| irq_taken | output | 1 | Interrupt accepted this cycle |
| stk_overflow | output | 1 | Sticky: push onto a full stack |
| stk_underflow | output | 1 | Sticky: pop from an empty stack |

## Verification
The hardest condition to reach from the ports is a full return stack receiving one more push while the eight saved entries still have to come back in order. The stimulus gets there with nine calls in a row, each to a different target. It then checks the overflow flag and that the PC still moved. Eight returns follow, and each one is compared against the address after the matching call. A ninth return then shows the underflow path. Interrupt entry is tested in the same cycle as a return strobe, which shows that the interrupt wins and that its saved address differs from the one a call would save.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    typedef enum logic [2:0] {
        SEL_HOLD,
        SEL_INC,
        SEL_BRANCH,
        SEL_JUMP,
        SEL_CALL,
        SEL_RET,
        SEL_IRQ
    } nxt_sel_t;

    typedef struct packed {
        logic fetch;
        logic jump;
        logic branch;
        logic cond;
        logic call;
        logic ret;
        logic irq;
    } ctl_t;

    function automatic nxt_sel_t pick_source(input ctl_t c);
        nxt_sel_t s;
        s = SEL_HOLD;
        if (c.fetch) begin
            if (c.irq)                    s = SEL_IRQ;
            else if (c.ret)               s = SEL_RET;
            else if (c.call)              s = SEL_CALL;
            else if (c.jump)              s = SEL_JUMP;
            else if (c.branch && c.cond)  s = SEL_BRANCH;
            else                          s = SEL_INC;
        end
        return s;
    endfunction

endpackage

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data,
    output logic         empty,
    output logic         full,
    output logic         ovf,
    output logic         unf
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_m1;

    assign empty  = (cnt == '0);
    assign full   = (cnt == CNT_W'(DEPTH));
    assign cnt_m1 = cnt - CNT_W'(1);
    assign top_data = empty ? '0 : mem[cnt_m1[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            if (push) begin
                if (full) ovf <= 1'b1;
                else      cnt <= cnt + CNT_W'(1);
            end else if (pop) begin
                if (empty) unf <= 1'b1;
                else       cnt <= cnt_m1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && push && !full) mem[cnt[IDX_W-1:0]] <= push_data;
    end

    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));
    assert_full_push_dropped_R8: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> (full && ovf));
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
    assert_empty_pop_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && empty) |=> (empty && unf));
endmodule

// File: rtl/pc_vec_table.sv
module pc_vec_table #(
    parameter int N = 4,
    parameter int W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wr_idx,
    input  logic [W-1:0]         wr_data,
    input  logic [$clog2(N)-1:0] rd_idx,
    output logic [W-1:0]         rd_data
);
    logic [W-1:0] ent [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)                           ent[g] <= '0;
            else if (we && wr_idx == g[$clog2(N)-1:0]) ent[g] <= wr_data;
        end
    end

    assign rd_data = ent[rd_idx];

    assert_vec_write_R12: assert property (@(posedge clk) disable iff (rst)
        we |=> (ent[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/pc_next_addr.sv
module pc_next_addr
    import pc_seq_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int OFS_W = 8
) (
    input  ctl_t             ctl,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [OFS_W-1:0] ofs,
    input  logic [PC_W-1:0]  tgt,
    input  logic [PC_W-1:0]  vec,
    input  logic [PC_W-1:0]  stk_top,
    input  logic             stk_empty,
    output nxt_sel_t         sel,
    output logic [PC_W-1:0]  nxt_pc,
    output logic             push,
    output logic             pop,
    output logic [PC_W-1:0]  push_data
);
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] ofs_ext;
    logic [PC_W-1:0] rel_pc;

    assign seq_pc  = cur_pc + PC_W'(1);
    assign ofs_ext = PC_W'($signed(ofs));
    assign rel_pc  = cur_pc + ofs_ext;
    assign sel     = pick_source(ctl);

    always_comb begin
        unique case (sel)
            SEL_INC:    nxt_pc = seq_pc;
            SEL_BRANCH: nxt_pc = rel_pc;
            SEL_JUMP:   nxt_pc = tgt;
            SEL_CALL:   nxt_pc = tgt;
            SEL_RET:    nxt_pc = stk_empty ? cur_pc : stk_top;
            SEL_IRQ:    nxt_pc = vec;
            default:    nxt_pc = cur_pc;
        endcase
    end

    assign push      = (sel == SEL_CALL) || (sel == SEL_IRQ);
    assign pop       = (sel == SEL_RET);
    assign push_data = (sel == SEL_IRQ) ? cur_pc : seq_pc;
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pc_seq_pkg::*;
#(
    parameter int PC_W      = 12,
    parameter int OFS_W     = 8,
    parameter int STK_DEPTH = 8,
    parameter int NUM_VEC   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       stall,
    input  logic                       fetch_vld,
    input  logic                       jump_en,
    input  logic                       branch_en,
    input  logic                       branch_cond,
    input  logic                       call_en,
    input  logic                       ret_en,
    input  logic [OFS_W-1:0]           branch_ofs,
    input  logic [PC_W-1:0]            target,
    input  logic                       irq_req,
    input  logic [$clog2(NUM_VEC)-1:0] irq_num,
    input  logic                       vec_we,
    input  logic [$clog2(NUM_VEC)-1:0] vec_idx,
    input  logic [PC_W-1:0]            vec_addr,
    output logic [PC_W-1:0]            pc,
    output logic                       irq_taken,
    output logic                       stk_overflow,
    output logic                       stk_underflow
);
    ctl_t            ctl;
    nxt_sel_t        sel;
    logic [PC_W-1:0] nxt_pc;
    logic [PC_W-1:0] vec_pc;
    logic [PC_W-1:0] stk_top;
    logic [PC_W-1:0] push_data;
    logic            stk_empty;
    logic            stk_full;
    logic            push;
    logic            pop;

    always_comb begin
        ctl.fetch  = fetch_vld && !stall && !rst;
        ctl.jump   = jump_en;
        ctl.branch = branch_en;
        ctl.cond   = branch_cond;
        ctl.call   = call_en;
        ctl.ret    = ret_en;
        ctl.irq    = irq_req;
    end

    pc_vec_table #(.N(NUM_VEC), .W(PC_W)) u_vec (
        .clk     (clk),
        .rst     (rst),
        .we      (vec_we),
        .wr_idx  (vec_idx),
        .wr_data (vec_addr),
        .rd_idx  (irq_num),
        .rd_data (vec_pc)
    );

    pc_next_addr #(.PC_W(PC_W), .OFS_W(OFS_W)) u_nxt (
        .ctl       (ctl),
        .cur_pc    (pc),
        .ofs       (branch_ofs),
        .tgt       (target),
        .vec       (vec_pc),
        .stk_top   (stk_top),
        .stk_empty (stk_empty),
        .sel       (sel),
        .nxt_pc    (nxt_pc),
        .push      (push),
        .pop       (pop),
        .push_data (push_data)
    );

    pc_ret_stack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .top_data  (stk_top),
        .empty     (stk_empty),
        .full      (stk_full),
        .ovf       (stk_overflow),
        .unf       (stk_underflow)
    );

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= nxt_pc;
    end

    assign irq_taken = (sel == SEL_IRQ);

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (pc == '0 && !stk_overflow && !stk_underflow));
    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pc));
    assert_no_fetch_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !fetch_vld |=> $stable(pc));
    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (fetch_vld && !stall && !irq_req && !ret_en && !call_en && !jump_en && !branch_en)
        |=> (pc == $past(pc) + PC_W'(1)));
    assert_irq_boundary_R9: assert property (@(posedge clk) disable iff (rst)
        irq_taken |-> (fetch_vld && !stall));
    assert_single_stack_op_R10: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));
    assert_jump_target_R3: assert property (@(posedge clk) disable iff (rst)
        (fetch_vld && !stall && jump_en && !irq_req && !ret_en && !call_en)
        |=> (pc == $past(target)));
endmodule

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic       fv;
        logic       jmp;
        logic       br;
        logic       cond;
        logic       call;
        logic       ret;
        logic [7:0] ofs;
        logic [11:0] tgt;
        logic [11:0] exp;
        logic [3:0]  req;
    } row_t;

    // Rows run from reset (pc = 0). req holds the requirement number:
    // R2 increment/hold, R3 jump, R4 branch, R5 wrap, R6 call/return, R7 nesting
    localparam row_t TBL [16] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,12'h000,12'h001,4'd2},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,12'h000,12'h002,4'd2},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,12'h100,12'h100,4'd3},
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,8'h10,12'h000,12'h110,4'd4},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h10,12'h000,12'h111,4'd4},
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,8'hFE,12'h000,12'h10F,4'd4},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,12'h200,12'h200,4'd6},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,12'h000,12'h201,4'd2},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,12'h300,12'h300,4'd6},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,12'h000,12'h202,4'd6},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,12'h000,12'h110,4'd7},
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,8'h00,12'h555,12'h110,4'd2},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,12'hFFF,12'hFFF,4'd3},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,12'h000,12'h000,4'd5},
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,8'hFF,12'h000,12'hFFF,4'd5},
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,8'h03,12'h000,12'h002,4'd5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic        fetch_vld = 1'b0;
    logic        jump_en = 1'b0;
    logic        branch_en = 1'b0;
    logic        branch_cond = 1'b0;
    logic        call_en = 1'b0;
    logic        ret_en = 1'b0;
    logic [7:0]  branch_ofs = '0;
    logic [11:0] target = '0;
    logic        irq_req = 1'b0;
    logic [1:0]  irq_num = '0;
    logic        vec_we = 1'b0;
    logic [1:0]  vec_idx = '0;
    logic [11:0] vec_addr = '0;
    logic [11:0] pc;
    logic        irq_taken;
    logic        stk_overflow;
    logic        stk_underflow;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_sequencer u_pc_sequencer (
        .clk(clk), .rst(rst), .stall(stall), .fetch_vld(fetch_vld),
        .jump_en(jump_en), .branch_en(branch_en), .branch_cond(branch_cond),
        .call_en(call_en), .ret_en(ret_en), .branch_ofs(branch_ofs),
        .target(target), .irq_req(irq_req), .irq_num(irq_num),
        .vec_we(vec_we), .vec_idx(vec_idx), .vec_addr(vec_addr),
        .pc(pc), .irq_taken(irq_taken), .stk_overflow(stk_overflow),
        .stk_underflow(stk_underflow)
    );

    task automatic check(input string req, input string what,
                         input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic idle();
        stall = 0; fetch_vld = 0; jump_en = 0; branch_en = 0; branch_cond = 0;
        call_en = 0; ret_en = 0; branch_ofs = '0; target = '0;
        irq_req = 0; irq_num = '0; vec_we = 0; vec_idx = '0; vec_addr = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic op(input logic j, input logic c, input logic r, input logic [11:0] t);
        idle();
        fetch_vld = 1; jump_en = j; call_en = c; ret_en = r; target = t;
        tick();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        int n = 0;
        while (!done && n < WATCHDOG) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected=<%0d", n, WATCHDOG);
            summary();
        end
    end

    initial begin
        idle();
        rst = 1;
        tick(); tick();
        // R1: reset state
        check("R1", "pc after reset", pc, 12'h000);
        check("R1", "overflow after reset", {11'b0, stk_overflow}, 12'h000);
        check("R1", "underflow after reset", {11'b0, stk_underflow}, 12'h000);
        rst = 0;

        for (int i = 0; i < 16; i++) begin
            idle();
            fetch_vld   = TBL[i].fv;
            jump_en     = TBL[i].jmp;
            branch_en   = TBL[i].br;
            branch_cond = TBL[i].cond;
            call_en     = TBL[i].call;
            ret_en      = TBL[i].ret;
            branch_ofs  = TBL[i].ofs;
            target      = TBL[i].tgt;
            tick();
            check($sformatf("R%0d", TBL[i].req), $sformatf("table row %0d", i), pc, TBL[i].exp);
        end

        // R8: pop on empty stack holds pc and sets underflow; R3 jumps left nothing stacked
        op(0, 0, 1, 12'h000);
        check("R8", "pop empty pc", pc, 12'h002);
        check("R3", "underflow after jumps only", {11'b0, stk_underflow}, 12'h001);

        // R10: precedence
        op(0, 1, 0, 12'h040);
        check("R6", "call target", pc, 12'h040);
        op(1, 1, 1, 12'h500);
        check("R10", "return beats call and jump", pc, 12'h003);
        op(1, 1, 0, 12'h080);
        check("R10", "call beats jump", pc, 12'h080);
        op(0, 0, 1, 12'h000);
        check("R10", "call beat jump so return works", pc, 12'h004);
        idle(); fetch_vld = 1; jump_en = 1; branch_en = 1; branch_cond = 1;
        branch_ofs = 8'h05; target = 12'h300;
        tick();
        check("R10", "jump beats branch", pc, 12'h300);

        // R12: handler table writes (core idle)
        idle(); vec_we = 1; vec_idx = 2'd2; vec_addr = 12'h7A0; tick();
        idle(); vec_we = 1; vec_idx = 2'd1; vec_addr = 12'h123; stall = 1; tick();
        check("R12", "pc held during table writes", pc, 12'h300);

        // R9 / R10: interrupt beats return in the same cycle
        idle(); fetch_vld = 1; ret_en = 1; irq_req = 1; irq_num = 2'd2;
        #1;
        check("R9", "irq_taken at boundary", {11'b0, irq_taken}, 12'h001);
        tick();
        check("R12", "vector 2 entry", pc, 12'h7A0);
        op(0, 0, 0, 12'h000);
        check("R2", "handler increments", pc, 12'h7A1);
        op(0, 0, 1, 12'h000);
        check("R9", "return to interrupted pc", pc, 12'h300);
        idle(); irq_req = 1; irq_num = 2'd1;
        #1;
        check("R9", "no irq without fetch_vld", {11'b0, irq_taken}, 12'h000);
        tick();
        check("R9", "pc held without fetch_vld", pc, 12'h300);
        idle(); fetch_vld = 1; irq_req = 1; irq_num = 2'd1; stall = 1;
        #1;
        check("R11", "no irq while stalled", {11'b0, irq_taken}, 12'h000);
        tick();
        idle(); fetch_vld = 1; irq_req = 1; irq_num = 2'd1; tick();
        check("R12", "vector 1 entry", pc, 12'h123);
        op(0, 0, 1, 12'h000);
        check("R9", "second return", pc, 12'h300);

        // R11: stall freezes pc and stack
        op(0, 1, 0, 12'h600);
        idle(); fetch_vld = 1; ret_en = 1; stall = 1; tick();
        check("R11", "stall with return", pc, 12'h600);
        idle(); fetch_vld = 1; jump_en = 1; target = 12'h700; stall = 1; tick();
        check("R11", "stall with jump", pc, 12'h600);
        op(0, 0, 1, 12'h000);
        check("R11", "stack intact after stall", pc, 12'h301);

        // R1: reset mid-run with strobes active
        idle(); rst = 1; fetch_vld = 1; call_en = 1; irq_req = 1; target = 12'h444;
        #1;
        check("R1", "irq_taken low in reset", {11'b0, irq_taken}, 12'h000);
        tick();
        rst = 0;
        check("R1", "pc after mid-run reset", pc, 12'h000);
        check("R1", "underflow cleared", {11'b0, stk_underflow}, 12'h000);

        // R8 / R7: fill, overflow, unwind
        for (int k = 1; k <= 9; k++) begin
            op(0, 1, 0, 12'(k * 16));
        end
        check("R8", "pc moves on dropped push", pc, 12'h090);
        check("R8", "overflow set", {11'b0, stk_overflow}, 12'h001);
        for (int k = 8; k >= 1; k--) begin
            op(0, 0, 1, 12'h000);
            check("R7", $sformatf("unwind level %0d", k), pc, 12'((k - 1) * 16 + 1));
        end
        check("R8", "overflow sticky", {11'b0, stk_overflow}, 12'h001);
        op(0, 0, 1, 12'h000);
        check("R8", "ninth pop holds pc", pc, 12'h001);
        check("R8", "underflow set", {11'b0, stk_underflow}, 12'h001);

        done = 1'b1;
        summary();
    end
endmodule